// File: doc/BRIEF.md
# Two-Branch Completion Join

This block merges the completion of two concurrently running branches into a single completion event. Each branch reports that it has finished with a one-cycle pulse. The two pulses may arrive in the same clock cycle or be any number of cycles apart, in either order. The block raises one single-cycle `done` pulse as soon as both branches have reported.

A branch that finishes first is held in a sticky pending flag, one flag per branch. When the other branch's pulse arrives, `done` goes high combinationally in that same cycle, and both flags are cleared on the following edge. The block is then ready for the next join straight away. A second pulse from a branch that is already pending is absorbed and is not counted twice.

The block carries no data, only the start/finish handshake. The only storage elements are the two flags, and there is no combinational path from the block's outputs back to its inputs.

Top module: `fork_join_sync`

## Requirements
- R1: While the synchronous active-high `rst` is high, `done` is low. After a reset cycle, no branch is pending, even if a branch had reported before the reset.
- R2: When `fin_a` and `fin_b` are both high in the same cycle and neither branch is pending, `done` is high in that same cycle.
- R3: When `fin_a` pulses first and `fin_b` pulses k ≥ 1 cycles later, `done` stays low until the `fin_b` cycle and is high in that cycle.
- R4: When `fin_b` pulses first and `fin_a` pulses k ≥ 1 cycles later, `done` stays low until the `fin_a` cycle and is high in that cycle.
- R5: `done` is high for exactly one cycle per join. It is high in the next cycle only if a fresh same-cycle pair `fin_a`=`fin_b`=1 arrives.
- R6: A repeated pulse on a branch that is already pending has no effect. `done` stays low until the other branch reports, and then fires exactly once.
- R7: Both pending flags clear in the cycle `done` fires, so a new join may begin in the very next cycle. Back-to-back joins each produce their own pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fin_a | input | 1 | Completion pulse from branch A |
| fin_b | input | 1 | Completion pulse from branch B |
| done | output | 1 | One-cycle join completion pulse |

## Verification
A stuck-set pending flag shows up as an early `done`: the pulse appears in the same cycle as the other branch's first pulse of the next join, one or more cycles before the expected tick. A stuck-clear flag shows up as a missing `done` in the cycle of the later pulse. A flag that is not cleared when the join fires shows up as a spurious `done` at the first lone pulse after that join. The scoreboard records the exact cycle each pulse is expected in, so any of these faults is caught at the first cycle it affects.

// File: rtl/fj_pkg.sv
package fj_pkg;
  localparam int unsigned FJ_BRANCHES = 2;
  localparam int unsigned FJ_IDX_A    = 0;
  localparam int unsigned FJ_IDX_B    = 1;
  typedef logic [FJ_BRANCHES-1:0] fj_vec_t;
endpackage

// File: rtl/fj_pending_flag.sv
module fj_pending_flag (
  input  logic clk,
  input  logic rst,
  input  logic fin,
  input  logic clear,
  output logic pending
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst)        pend_q <= 1'b0;
    else if (clear) pend_q <= 1'b0;
    else if (fin)   pend_q <= 1'b1;
  end

  assign pending = pend_q;

  assert_flag_reset_R1: assert property (@(posedge clk) rst |=> !pending);
  assert_flag_sets_R3: assert property (@(posedge clk) disable iff (rst)
    (fin && !clear) |=> pending);
  assert_flag_clears_R7: assert property (@(posedge clk) disable iff (rst)
    clear |=> !pending);
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (pending && !clear) |=> pending);
endmodule

// File: rtl/fj_join_detect.sv
module fj_join_detect
  import fj_pkg::*;
(
  input  logic    rst,
  input  fj_vec_t fin_vec,
  input  fj_vec_t pend_vec,
  output logic    join_fire
);
  fj_vec_t seen;

  always_comb begin
    seen      = fin_vec | pend_vec;
    join_fire = !rst && (&seen);
  end
endmodule

// File: rtl/fork_join_sync.sv
module fork_join_sync
  import fj_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fin_a,
  input  logic fin_b,
  output logic done
);
  fj_vec_t fin_vec;
  fj_vec_t pend_vec;
  logic    fire;

  assign fin_vec[FJ_IDX_A] = fin_a;
  assign fin_vec[FJ_IDX_B] = fin_b;

  for (genvar g = 0; g < FJ_BRANCHES; g++) begin : g_branch
    fj_pending_flag u_flag (
      .clk     (clk),
      .rst     (rst),
      .fin     (fin_vec[g]),
      .clear   (fire),
      .pending (pend_vec[g])
    );
  end

  fj_join_detect u_detect (
    .rst       (rst),
    .fin_vec   (fin_vec),
    .pend_vec  (pend_vec),
    .join_fire (fire)
  );

  assign done = fire;

  assert_no_done_in_reset_R1: assert property (@(posedge clk) rst |-> !done);
  assert_same_tick_join_R2: assert property (@(posedge clk) disable iff (rst)
    (fin_a && fin_b && pend_vec == '0) |-> done);
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done || (fin_a && fin_b)));
  assert_lone_pulse_silent_R3: assert property (@(posedge clk) disable iff (rst)
    (pend_vec == '0 && fin_a && !fin_b) |-> !done);
  assert_lone_pulse_silent_R4: assert property (@(posedge clk) disable iff (rst)
    (pend_vec == '0 && fin_b && !fin_a) |-> !done);
endmodule

// File: tb/fork_join_sync_tb.sv
`timescale 1ns/1ps
module fork_join_sync_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fin_a = 1'b0;
  logic fin_b = 1'b0;
  logic done;

  int   cyc = 0;
  int   n_tests = 0;
  int   n_fail = 0;
  bit   running = 1'b1;
  int   exp_q[$];
  string cur_req = "R1";

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fork_join_sync u_dut (
    .clk   (clk),
    .rst   (rst),
    .fin_a (fin_a),
    .fin_b (fin_b),
    .done  (done)
  );

  // one driven cycle; exp=1 means done is required in this cycle
  task automatic step(input logic a, input logic b, input bit exp);
    @(negedge clk);
    fin_a = a;
    fin_b = b;
    if (exp) exp_q.push_back(cyc);
  endtask

  // ordered join: first branch, gap idle cycles, then the second branch
  task automatic join_pair(input int gap, input bit a_first);
    if (gap == 0) begin
      step(1, 1, 1);
    end else begin
      step(a_first, !a_first, 0);
      for (int i = 1; i < gap; i++) step(0, 0, 0);
      step(!a_first, a_first, 1);
    end
  endtask

  // scoreboard monitor: samples 1 ns before each rising edge
  initial begin
    while (running) begin
      @(negedge clk);
      #1.5;
      if (!running) break;
      n_tests++;
      if (exp_q.size() > 0 && exp_q[0] == cyc) begin
        void'(exp_q.pop_front());
        if (done !== 1'b1) begin
          n_fail++;
          $display("FAIL %s cycle %0d: done=%b expected 1", cur_req, cyc, done);
        end
      end else if (done !== 1'b0) begin
        n_fail++;
        $display("FAIL %s cycle %0d: done=%b expected 0", cur_req, cyc, done);
      end
    end
  end

  // watchdog
  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state, done held low even with both inputs high
    cur_req = "R1";
    step(0, 0, 0);
    step(1, 1, 0);
    step(0, 0, 0);
    rst = 1'b0;
    step(0, 0, 0);

    // R2: same-cycle arrival
    cur_req = "R2";
    join_pair(0, 1);
    step(0, 0, 0);
    join_pair(0, 0);
    step(0, 0, 0);

    // R3: A first, gaps 1..10
    cur_req = "R3";
    for (int g = 1; g <= 10; g++) begin
      join_pair(g, 1);
      step(0, 0, 0);
    end

    // R4: B first, gaps 1..10
    cur_req = "R4";
    for (int g = 1; g <= 10; g++) begin
      join_pair(g, 0);
      step(0, 0, 0);
    end

    // R5: single-cycle pulse, quiet afterwards, lone pulse does not refire
    cur_req = "R5";
    join_pair(3, 1);
    step(0, 0, 0);
    step(0, 0, 0);
    step(1, 0, 0);
    step(0, 1, 1);
    step(0, 0, 0);

    // R6: repeated pulse on a pending branch is absorbed
    cur_req = "R6";
    step(1, 0, 0);
    step(1, 0, 0);
    step(0, 0, 0);
    step(1, 0, 0);
    step(0, 1, 1);
    step(0, 0, 0);
    step(0, 1, 0);
    step(0, 1, 0);
    step(1, 0, 1);
    step(0, 0, 0);
    // pending A then both high: one join, flags cleared after
    step(1, 0, 0);
    step(1, 1, 1);
    step(0, 1, 0);
    step(1, 0, 1);

    // R7: back-to-back joins with no idle cycle between
    cur_req = "R7";
    step(1, 1, 1);
    step(1, 1, 1);
    step(1, 0, 0);
    step(0, 1, 1);
    step(0, 1, 0);
    step(1, 0, 1);
    step(1, 1, 1);
    step(0, 0, 0);

    // R1: reset discards a pending branch
    cur_req = "R1";
    step(1, 0, 0);
    @(negedge clk);
    rst = 1'b1;
    fin_a = 1'b0;
    fin_b = 1'b0;
    step(0, 0, 0);
    rst = 1'b0;
    step(0, 1, 0);
    step(1, 0, 1);
    step(0, 0, 0);
    step(0, 0, 0);

    running = 1'b0;
    @(negedge clk);
    n_tests++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R5 scoreboard: %0d pending expected pulses, expected 0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule